// File: doc/BRIEF.md
# Master Clock Source Selector and Divider

This block produces a master clock and a processor clock from four free-running clock inputs: a slow clock, a main clock, a first PLL clock and a second PLL clock. A configuration word written through a single-register port chooses the input, a power-of-two prescale ratio, a final divide ratio of 1, 2, 4 or 3, and an optional halving of the first PLL input. The processor clock is tapped after the prescaler. The master clock is taken after the final divider.

Any write that changes the configuration starts a switch sequence. The running source is gated off on its own falling edge. The divider counters are cleared while the output is stopped. The new source is then gated on after two synchronizing edges of that source. A ready flag reads low from the cycle after the write until the new configuration drives the outputs. Software polls the flag and does not use the clocks until it reads high.

Top module: `mck_gen`

## Requirements
- R1: Source field code 0 selects the slow clock, 1 the main clock, 2 the first PLL clock and 3 the second PLL clock. With prescale and final divide of 1, the master clock has the period of the selected input.
- R2: Prescale field code k (k = 0..6) divides the selected clock by 2^k. Code 7 divides by 64.
- R3: Final divide field codes 0, 1, 2 and 3 divide the prescaled clock by 1, 2, 4 and 3.
- R4: The processor clock is the prescaled clock, so its period is the master clock period divided by the final divide ratio.
- R5: When the halving bit is set, the first PLL input is divided by 2 before selection. The bit does not change the frequency of any other source.
- R6: In the cycle after a write whose value differs from the stored configuration, the ready flag reads 0. It reads 1 again only after the new configuration drives the outputs. A write of the stored value leaves ready at 1. The last of several writes made during a switch is the one that takes effect.
- R7: While configurations change, the master clock never shows a high or low pulse shorter than half the period of the fastest input.
- R8: For final divide ratios 1, 2 and 4 the master clock has a 50% duty cycle. For ratio 3 its high time is one prescaled-clock period.
- R9: After reset, the read port returns 0x100 (slow clock, all ratios 1, ready set), and the master clock runs at the slow clock period.
- R10: The read word holds the source in bits [1:0], the prescale code in [4:2], the final divide code in [6:5], the halving bit in [7] and ready in [8]. Bits [7:0] return the last written configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 8 | Configuration word to write |
| rd_data | output | 9 | Ready flag and requested configuration |
| slow_clk | input | 1 | Slow clock input |
| main_clk | input | 1 | Main clock input |
| plla_clk | input | 1 | First PLL clock input |
| upll_clk | input | 1 | Second PLL clock input |
| mck | output | 1 | Master clock |
| pck | output | 1 | Processor clock |

## Verification
The bench sweeps every source, every prescale code (including the out-of-range code 7) and every final divide code, with both halving settings on the first PLL. Each case measures period, high time and processor-clock period against arithmetic expectations. A decoder that swaps codes 2 and 3 of the final divider shows up as a period that is wrong by a factor of 4/3. A mis-tapped prescaler gives a period off by a power of two, and a halving bit that leaks onto another source doubles that source's period. Edge-to-edge spacing is monitored for the whole run, so a switch that does not stop the old clock first leaves a sliver pulse. The bench also checks that ready falls the cycle after a changing write, stays high on a same-value write, and follows the last of two back-to-back writes.

// File: rtl/mck_gen.sv
`timescale 1ns/1ps
module mck_gen #(
  parameter int PRES_MAX = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [8:0] rd_data,
  input  logic       slow_clk,
  input  logic       main_clk,
  input  logic       plla_clk,
  input  logic       upll_clk,
  output logic       mck,
  output logic       pck
);
  localparam logic [2:0] PMAX = 3'(PRES_MAX);

  typedef enum logic [1:0] {RUN, STOP, LOAD, START} st_t;

  st_t        state;
  logic [7:0] req, act;
  logic [3:0] want_q, ack_s1, ack_s2, gclk, en_v;
  logic       clr_q, plla_h, ready;
  logic [3:0] srcs;
  logic       mux_clk, cnt_rst;
  logic [PRES_MAX-1:0] pcnt;
  logic [1:0] mcnt;
  logic       d3q;
  logic [2:0] pe;

  always_ff @(posedge plla_clk or negedge rst_n)
    if (!rst_n) plla_h <= 1'b0;
    else        plla_h <= ~plla_h;

  assign srcs = {upll_clk, act[7] ? plla_h : plla_clk, main_clk, slow_clk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RUN;
      req    <= '0;
      act    <= '0;
      clr_q  <= 1'b0;
      want_q <= 4'b0001;
      ack_s1 <= 4'b0001;
      ack_s2 <= 4'b0001;
    end else begin
      if (wr_en) req <= wr_data;
      ack_s1 <= en_v;
      ack_s2 <= ack_s1;
      want_q <= ((state == RUN) || (state == START)) ? (4'b0001 << act[1:0]) : 4'b0000;
      case (state)
        RUN:   if (req != act) state <= STOP;
        STOP:  if (ack_s2 == 4'b0000 && want_q == 4'b0000) begin
                 state <= LOAD;
                 clr_q <= 1'b1;
               end
        LOAD:  begin
                 act   <= req;
                 clr_q <= 1'b0;
                 state <= START;
               end
        START: if (ack_s2[act[1:0]]) state <= RUN;
        default: state <= RUN;
      endcase
    end
  end

  assign ready   = (state == RUN) && (req == act);
  assign rd_data = {ready, req};

  for (genvar i = 0; i < 4; i++) begin : g_gate
    localparam logic RV = (i == 0);
    logic s1, s2, en_l;
    always_ff @(posedge srcs[i] or negedge rst_n)
      if (!rst_n) begin s1 <= RV; s2 <= RV; end
      else        begin s1 <= want_q[i]; s2 <= s1; end
    always_ff @(negedge srcs[i] or negedge rst_n)
      if (!rst_n) en_l <= RV;
      else        en_l <= s2;
    assign en_v[i] = en_l;
    assign gclk[i] = srcs[i] & en_l;
  end

  assign mux_clk = |gclk;
  assign cnt_rst = ~rst_n | clr_q;

  always_ff @(posedge mux_clk or posedge cnt_rst)
    if (cnt_rst) pcnt <= '0;
    else         pcnt <= pcnt + 1'b1;

  assign pe = (act[4:2] > PMAX) ? PMAX : act[4:2];

  logic [PRES_MAX:0] taps;
  assign taps = {pcnt, mux_clk};
  assign pck  = taps[pe];

  always_ff @(posedge pck or posedge cnt_rst) begin
    if (cnt_rst) begin
      mcnt <= 2'd0;
      d3q  <= 1'b0;
    end else if (act[6:5] == 2'd3) begin
      mcnt <= (mcnt == 2'd2) ? 2'd0 : mcnt + 2'd1;
      d3q  <= (mcnt == 2'd2);
    end else begin
      mcnt <= mcnt + 2'd1;
      d3q  <= 1'b0;
    end
  end

  always_comb
    case (act[6:5])
      2'd0:    mck = pck;
      2'd1:    mck = mcnt[0];
      2'd2:    mck = mcnt[1];
      default: mck = d3q;
    endcase

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != req) |=> !rd_data[8]);

  a_r7_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_s2));

  a_r6_ready_means_live: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ack_s2 == (4'b0001 << act[1:0])));

  a_r7_clear_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> (ack_s2 == 4'b0000));

  a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[7:0]));
endmodule

// File: tb/tb_mck_gen.sv
`timescale 1ns/1ps
module tb_mck_gen;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [8:0] rd_data;
  logic slow_clk = 0, main_clk = 0, plla_clk = 0, upll_clk = 0;
  logic mck, pck;
  int checks = 0, fails = 0, cycles = 0, glitches = 0;
  real last_edge = -1.0;

  always #5 clk = ~clk;
  always #7 slow_clk = ~slow_clk;
  always #3 main_clk = ~main_clk;
  always #2 plla_clk = ~plla_clk;
  always #4 upll_clk = ~upll_clk;

  mck_gen dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
               .slow_clk(slow_clk), .main_clk(main_clk), .plla_clk(plla_clk), .upll_clk(upll_clk),
               .mck(mck), .pck(pck));

  always @(mck) begin
    if (last_edge >= 0.0 && ($realtime - last_edge) < 1.9) glitches++;
    last_edge = $realtime;
  end

  task automatic chk(input bit ok, input string tag, input real a, input real e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, a, e);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 5000 && !rd_data[8]; k++) @(negedge clk);
  endtask

  task automatic measure(output real per, output real hi, output real pper);
    real t1, t2, t3;
    @(posedge mck); @(posedge mck); t1 = $realtime;
    @(negedge mck); t2 = $realtime;
    @(posedge mck); t3 = $realtime;
    per = t3 - t1; hi = t2 - t1;
    @(posedge pck); t1 = $realtime;
    @(posedge pck); pper = $realtime - t1;
  endtask

  function automatic real src_per(input int s, input bit h);
    real p;
    case (s) 0: p = 14.0; 1: p = 6.0; 2: p = 4.0; default: p = 8.0; endcase
    if (s == 2 && h) p = p * 2.0;
    return p;
  endfunction

  task automatic run_cfg(input int s, input int p, input int m, input bit h);
    logic [7:0] v;
    real per, hi, pper, pp, ep, eh;
    int ratio;
    v = {h, 2'(m), 3'(p), 2'(s)};
    wr(v);
    chk(rd_data[7:0] == v, "R10 readback", real'(rd_data[7:0]), real'(v));
    wait_ready();
    chk(rd_data[8] == 1'b1, "R6 ready returns", real'(rd_data[8]), 1.0);
    measure(per, hi, pper);
    pp = src_per(s, h) * real'(1 << ((p > 6) ? 6 : p));
    ratio = (m == 3) ? 3 : (1 << m);
    ep = pp * real'(ratio);
    eh = (m == 3) ? pp : ep / 2.0;
    chk(near(per, ep), $sformatf("R1 R2 R3 R5 mck period s%0d p%0d m%0d h%0d", s, p, m, h), per, ep);
    chk(near(hi, eh), $sformatf("R8 high time s%0d p%0d m%0d", s, p, m), hi, eh);
    chk(near(pper, pp), $sformatf("R4 pck period s%0d p%0d m%0d", s, p, m), pper, pp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    real per, hi, pper;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_data == 9'h100, "R9 reset readback", real'(rd_data), 256.0);
    measure(per, hi, pper);
    chk(near(per, 14.0), "R9 reset mck period", per, 14.0);

    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 8; p++)
        for (int m = 0; m < 4; m++) begin
          run_cfg(s, p, m, 1'b0);
          if (s == 2) run_cfg(s, p, m, 1'b1);
        end

    run_cfg(1, 1, 0, 1'b1);
    run_cfg(3, 0, 1, 1'b1);

    // R6: a changing write drops ready in the next cycle
    wr(8'h09);
    chk(rd_data[8] == 1'b0, "R6 ready low after change", real'(rd_data[8]), 0.0);
    wait_ready();
    // R6: rewriting the same value leaves ready high
    wr(8'h09);
    for (int k = 0; k < 20; k++) begin
      chk(rd_data[8] == 1'b1, "R6 same value keeps ready", real'(rd_data[8]), 1.0);
      @(negedge clk);
    end
    // R6: back-to-back writes, the last one wins
    wr(8'h00);
    wr(8'h43);
    wait_ready();
    chk(rd_data == 9'h143, "R6 last write wins readback", real'(rd_data), 323.0);
    measure(per, hi, pper);
    chk(near(per, 32.0), "R6 last write wins period", per, 32.0);

    chk(glitches == 0, "R7 no short pulses", real'(glitches), 0.0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule